// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block sits between a CPU and its bus fabric and decides which bus target each physical address belongs to. It holds a set of decode windows, each programmed with a base, a size mask in 64 KB units, a target identifier, an attribute byte and an enable bit. An address is compared against every window in parallel. The block reports whether any window hit, the target and attribute of the winning window, and the address to forward on the bus.

Software sets up the windows through a small register port: one write strobe, a byte offset and 32 bits of data, with a combinational read of the same offset. The two lowest windows can also translate addresses. On a hit in one of them, the upper address bits outside the size mask come from a remap register, so a region seen by the CPU can be moved anywhere in the target's space. The other windows forward the address unchanged.

Typical targets are DRAM (id 0), the device bus (id 1) and two PCIe ports (ids 3 and 4). Attribute bytes then select a chip select, a boot device or a PCIe memory or I/O space. The block gives these codes no meaning of its own and only carries them to its outputs.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads zero and no address produces a hit.
- R2: Window n occupies the byte offsets n*16 to n*16+15. Offset 0x0 is control, 0x4 is base, 0x8 is remap-low and 0xC is remap-high, and regAddr bits 1:0 are ignored. The base and remap-low registers keep only data bits 31:16 and read bits 15:0 as zero. Remap-high stores all 32 bits.
- R3: The control word holds the size mask in bits 31:16, the attribute in bits 15:8, the enable in bit 5 and the target in bits 3:0. Bits 7:6 and bit 4 read as zero.
- R4: An enabled window hits when cpuAddr[31:16] and the base agree in every bit where the size mask is 0.
- R5: A window whose enable bit is 0 never hits. Writing 0 to its control register disables it.
- R6: When several windows hit, the lowest-numbered one supplies target, attribute and translation.
- R7: On a miss, hit is 0, target and attr are 0, and xlatAddr equals cpuAddr.
- R8: On a hit in window 0 or 1, xlatAddr[31:16] = (remapLo & ~mask) | (cpuAddr[31:16] & mask).
- R9: Windows 2 to 7 forward cpuAddr unchanged on a hit. Their remap registers ignore writes and read as zero.
- R10: xlatAddr[15:0] always equals cpuAddr[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register file |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 7 | Byte offset for register read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at regAddr |
| cpuAddr | input | 32 | Address to decode |
| hit | output | 1 | Some enabled window matched |
| target | output | 4 | Target id of the winning window, zero on a miss |
| attr | output | 8 | Attribute of the winning window, zero on a miss |
| xlatAddr | output | 32 | Translated address |

## Verification
The assertions check on every cycle that:
- a miss gives zero target and attribute and forwards the address unchanged;
- the low 16 address bits are never altered;
- unimplemented remap registers read zero;
- base reads carry no low bits;
- nothing hits before the first control write after reset.

Only the bench scenarios can show the results that depend on what was programmed: the match rule, the remap arithmetic, which window wins when two overlap, and the effect of disabling a window.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int REG_W  = 32;
  localparam int PAGE_W = 16;
  localparam int UP_W   = REG_W - PAGE_W;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_RMLO  = 2'd2,
    SEL_RMHI  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrBase;
    logic    wrRemapLo;
    logic    wrRemapHi;
    regSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/awd_regctl.sv
module awd_regctl
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int RADDR_W  = IDX_W + 4
) (
  input  logic               regWrEn,
  input  logic [RADDR_W-1:0] regAddr,
  output regStrobe_t         strobe,
  output logic [IDX_W-1:0]   winIdx
);
  logic    hasRemap;
  regSel_e sel;

  assign winIdx   = regAddr[RADDR_W-1:4];
  assign sel      = regSel_e'(regAddr[3:2]);
  assign hasRemap = (32'(winIdx) < NUM_REMAP);

  always_comb begin
    strobe           = '0;
    strobe.rdSel     = sel;
    strobe.wrCtrl    = regWrEn && (sel == SEL_CTRL);
    strobe.wrBase    = regWrEn && (sel == SEL_BASE);
    strobe.wrRemapLo = regWrEn && hasRemap && (sel == SEL_RMLO);
    strobe.wrRemapHi = regWrEn && hasRemap && (sel == SEL_RMHI);
  end
endmodule

// File: rtl/awd_datapath.sv
module awd_datapath
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  localparam int IDX_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [IDX_W-1:0]  winIdx,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [REG_W-1:0]  cpuAddr,
  output logic              hit,
  output logic [TGT_W-1:0]  target,
  output logic [ATTR_W-1:0] attr,
  output logic [REG_W-1:0]  xlatAddr
);
  logic [UP_W-1:0]   maskR    [NUM_WIN];
  logic [UP_W-1:0]   baseR    [NUM_WIN];
  logic [UP_W-1:0]   remapLoR [NUM_WIN];
  logic [REG_W-1:0]  remapHiR [NUM_WIN];
  logic [ATTR_W-1:0] attrR    [NUM_WIN];
  logic [TGT_W-1:0]  tgtR     [NUM_WIN];
  logic [NUM_WIN-1:0] enR;
  logic [NUM_WIN-1:0] hitVec;
  logic [UP_W-1:0]   addrUp;

  assign addrUp = cpuAddr[REG_W-1:PAGE_W];

  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    logic sel;
    assign sel = (winIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskR[i] <= '0;
        attrR[i] <= '0;
        enR[i]   <= 1'b0;
        tgtR[i]  <= '0;
      end else if (sel && strobe.wrCtrl) begin
        maskR[i] <= regWrData[31:16];
        attrR[i] <= regWrData[15:8];
        enR[i]   <= regWrData[5];
        tgtR[i]  <= regWrData[TGT_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     baseR[i] <= '0;
      else if (sel && strobe.wrBase) baseR[i] <= regWrData[REG_W-1:PAGE_W];
    end

    if (i < NUM_REMAP) begin : gRemap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          remapLoR[i] <= '0;
          remapHiR[i] <= '0;
        end else begin
          if (sel && strobe.wrRemapLo) remapLoR[i] <= regWrData[REG_W-1:PAGE_W];
          if (sel && strobe.wrRemapHi) remapHiR[i] <= regWrData;
        end
      end
    end else begin : gNoRemap
      assign remapLoR[i] = '0;
      assign remapHiR[i] = '0;
    end

    assign hitVec[i] = enR[i] && (((addrUp ^ baseR[i]) & ~maskR[i]) == '0);
  end

  // lowest index wins
  logic [IDX_W-1:0] winSel;
  logic             anyHit;
  always_comb begin
    winSel = '0;
    anyHit = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit = 1'b1;
        winSel = IDX_W'(i);
      end
    end
  end

  logic            doRemap;
  logic [UP_W-1:0] xlatUp;
  assign doRemap = anyHit && (32'(winSel) < NUM_REMAP);
  assign xlatUp  = doRemap ? ((remapLoR[winSel] & ~maskR[winSel]) | (addrUp & maskR[winSel]))
                           : addrUp;

  assign hit      = anyHit;
  assign target   = anyHit ? tgtR[winSel]  : '0;
  assign attr     = anyHit ? attrR[winSel] : '0;
  assign xlatAddr = {xlatUp, cpuAddr[PAGE_W-1:0]};

  always_comb begin
    unique case (strobe.rdSel)
      SEL_CTRL: regRdData = {maskR[winIdx], attrR[winIdx], 2'b00, enR[winIdx], 1'b0, tgtR[winIdx]};
      SEL_BASE: regRdData = {baseR[winIdx], {PAGE_W{1'b0}}};
      SEL_RMLO: regRdData = {remapLoR[winIdx], {PAGE_W{1'b0}}};
      default:  regRdData = remapHiR[winIdx];
    endcase
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int RADDR_W  = IDX_W + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [REG_W-1:0]   cpuAddr,
  output logic               hit,
  output logic [TGT_W-1:0]   target,
  output logic [ATTR_W-1:0]  attr,
  output logic [REG_W-1:0]   xlatAddr
);
  regStrobe_t       strobe;
  logic [IDX_W-1:0] winIdx;

  awd_regctl #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) uCtl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe),
    .winIdx  (winIdx)
  );

  awd_datapath #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .winIdx    (winIdx),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cpuAddr   (cpuAddr),
    .hit       (hit),
    .target    (target),
    .attr      (attr),
    .xlatAddr  (xlatAddr)
  );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int RADDR_W  = IDX_W + 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [RADDR_W-1:0] regAddr,
  input logic [31:0]        regWrData,
  input logic [31:0]        regRdData,
  input logic [31:0]        cpuAddr,
  input logic               hit,
  input logic [3:0]         target,
  input logic [7:0]         attr,
  input logic [31:0]        xlatAddr
);
  logic ctrlTouched;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlTouched <= 1'b0;
    else if (regWrEn && regAddr[3:2] == 2'b00 && regWrData != '0) ctrlTouched <= 1'b1;
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (target == '0 && attr == '0 && xlatAddr == cpuAddr)); // R7

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    xlatAddr[15:0] == cpuAddr[15:0]); // R10

  AST_NO_REMAP_READ: assert property (@(posedge clk) disable iff (!rstN)
    (32'(regAddr[RADDR_W-1:4]) >= NUM_REMAP && regAddr[3]) |-> regRdData == '0); // R9

  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[3:2] == 2'b01) |-> regRdData[15:0] == '0); // R2

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlTouched |-> !hit); // R1
endmodule

bind addr_window_decoder awd_checker #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .regRdData(regRdData), .cpuAddr(cpuAddr), .hit(hit), .target(target), .attr(attr),
  .xlatAddr(xlatAddr)
);

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] cpuAddr = '0;
  logic        hit;
  logic [3:0]  target;
  logic [7:0]  attr;
  logic [31:0] xlatAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  addr_window_decoder uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cpuAddr(cpuAddr),
    .hit(hit), .target(target), .attr(attr), .xlatAddr(xlatAddr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] xlat;
  } vec_t;

  // windows programmed below: 0 DDR remap, 1 device remap, 2/3 PCIe, 4 overlaps 2, 5 disabled
  localparam vec_t VEC [10] = '{
    '{32'h0123_4567, 1'b1, 4'd0, 8'h1E, 32'h4123_4567},  // R4 R8
    '{32'h0FFF_FFFF, 1'b1, 4'd0, 8'h1E, 32'h4FFF_FFFF},  // R8 top edge
    '{32'h1000_0000, 1'b0, 4'd0, 8'h00, 32'h1000_0000},  // R7
    '{32'h2000_ABCD, 1'b1, 4'd1, 8'h0F, 32'h7000_ABCD},  // R8 R10
    '{32'h2001_0000, 1'b0, 4'd0, 8'h00, 32'h2001_0000},  // R4 one past
    '{32'h8000_1234, 1'b1, 4'd3, 8'h59, 32'h8000_1234},  // R6 R9
    '{32'h87FF_FFFF, 1'b1, 4'd3, 8'h59, 32'h87FF_FFFF},  // R4 R9
    '{32'h8800_0000, 1'b1, 4'd4, 8'h59, 32'h8800_0000},  // R4
    '{32'hF000_0010, 1'b0, 4'd0, 8'h00, 32'hF000_0010},  // R5
    '{32'h9000_0000, 1'b0, 4'd0, 8'h00, 32'h9000_0000}   // R7
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic lookup(input logic [31:0] a, input logic eh, input logic [3:0] et,
                        input logic [7:0] ea, input logic [31:0] ex, input string req);
    @(negedge clk);
    cpuAddr = a;
    #1;
    check(hit == eh, {req, " hit"}, {31'b0, hit}, {31'b0, eh});
    check(target == et, {req, " target"}, {28'b0, target}, {28'b0, et});
    check(attr == ea, {req, " attr"}, {24'b0, attr}, {24'b0, ea});
    check(xlatAddr == ex, {req, " xlat"}, xlatAddr, ex);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int w = 0; w < 8; w++) begin
      for (int r = 0; r < 4; r++) begin
        rd(7'(w * 16 + r * 4), d);
        check(d == 32'h0, "R1 reset readback", d, 32'h0);
      end
    end
    lookup(32'h0000_0000, 1'b0, 4'd0, 8'h00, 32'h0000_0000, "R1");

    // program windows
    wr(7'h00, 32'h0FFF_1E20); wr(7'h04, 32'h0000_0000); wr(7'h08, 32'h4000_0000);
    wr(7'h10, 32'h0000_0F21); wr(7'h14, 32'h2000_0000); wr(7'h18, 32'h7000_0000);
    wr(7'h20, 32'h07FF_5923); wr(7'h24, 32'h8000_0000);
    wr(7'h30, 32'h07FF_5924); wr(7'h34, 32'h8800_0000);
    wr(7'h40, 32'h000F_1D21); wr(7'h44, 32'h8000_0000);
    wr(7'h50, 32'h00FF_1B01); wr(7'h54, 32'hF000_0000);

    for (int i = 0; i < 10; i++)
      lookup(VEC[i].addr, VEC[i].hit, VEC[i].tgt, VEC[i].attr, VEC[i].xlat, "R4/R6/R7/R8 vector");

    // R3 control readback and reserved bits
    rd(7'h20, d); check(d == 32'h07FF_5923, "R3 ctrl readback", d, 32'h07FF_5923);
    wr(7'h60, 32'hFFFF_FFFF);
    rd(7'h60, d); check(d == 32'hFFFF_FF2F, "R3 reserved bits zero", d, 32'hFFFF_FF2F);
    // R5 disable by zero write
    wr(7'h60, 32'h0);
    lookup(32'h9000_0000, 1'b0, 4'd0, 8'h00, 32'h9000_0000, "R5 disabled after zero");

    // R2 base low bits, byte offset bits ignored, remap-high full width
    wr(7'h74, 32'h1234_5678);
    rd(7'h74, d); check(d == 32'h1234_0000, "R2 base low zero", d, 32'h1234_0000);
    rd(7'h77, d); check(d == 32'h1234_0000, "R2 offset low bits ignored", d, 32'h1234_0000);
    wr(7'h0C, 32'hDEAD_BEEF);
    rd(7'h0C, d); check(d == 32'hDEAD_BEEF, "R2 remap-high", d, 32'hDEAD_BEEF);
    wr(7'h18, 32'h7000_FFFF);
    rd(7'h18, d); check(d == 32'h7000_0000, "R2 remap-low low zero", d, 32'h7000_0000);

    // R9 remap writes to window 3 ignored, and window 3 still passes through
    wr(7'h38, 32'hC000_0000); wr(7'h3C, 32'h1111_1111);
    rd(7'h38, d); check(d == 32'h0, "R9 remap-low unimplemented", d, 32'h0);
    rd(7'h3C, d); check(d == 32'h0, "R9 remap-high unimplemented", d, 32'h0);
    lookup(32'h8912_3456, 1'b1, 4'd4, 8'h59, 32'h8912_3456, "R9 pass-through");

    // R6: disable window 2, overlapping window 4 now wins
    wr(7'h20, 32'h0);
    lookup(32'h8000_1234, 1'b1, 4'd1, 8'h1D, 32'h8000_1234, "R6 next priority");
    lookup(32'h8010_0000, 1'b0, 4'd0, 8'h00, 32'h8010_0000, "R5 window 2 off");

    // R8 remap mixes only bits outside the mask
    wr(7'h08, 32'hF555_0000);
    lookup(32'h0ABC_0042, 1'b1, 4'd0, 8'h1E, 32'hFABC_0042, "R8 mask mix");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule